// File: doc/BRIEF.md
# Converter Serial Port Emulator (Chip-Select Mode with Busy Indicator)

This block emulates the digital side of a 16-bit successive-approximation converter's serial port in its four-wire chip-select mode with a busy indicator. A host drives three asynchronous pins into the block: a conversion strobe (`cnv_i`), a select/data-in pin (`sdi_i`) and a serial clock (`sck_i`). A parallel word (`sample_i`) stands in for the analog front end. The block drives a serial data output `sdo_o` together with `sdo_en_o`. When `sdo_en_o` is low, the output is in high impedance. The conversion time is counted in system clock cycles.

A conversion starts on a rising edge of the strobe while the select pin is high. The output is released during the conversion. When the conversion completes, the output is driven low. With a pull-up on the line, this high-to-low change acts as the host's interrupt. Falling serial-clock edges then present the latched word one bit at a time, most significant bit first. The 17th falling edge releases the output. A rise on the select pin also releases it, whichever comes first. All three pins pass through two-flop synchronizers, and edges are taken from the synchronized values.

The controller has five states. IDLE waits for a start. CONV times the conversion. DONE drives the low indicator. SHIFT presents data bits. HOLD keeps the output released until the strobe falls. The transitions are:
- IDLE→CONV on a start.
- CONV→DONE at completion with the select pin low.
- CONV→HOLD at completion with the select pin high.
- DONE→SHIFT on the first falling serial-clock edge.
- DONE/SHIFT→HOLD on a select-pin rise, or on the last falling edge.
- Any state→IDLE when the synchronized strobe is low.

Top module: `sar_port_emu`

## Requirements
- R1: A synchronized rising edge of `cnv_i` with `sdi_i` high and `turbo_i` low starts a conversion. The output is released (`sdo_en_o`=0) from the third clock edge after the pins change.
- R2: In IDLE, `sdo_en_o`=1 and `sdo_o`=0 when both synchronized `cnv_i` and `sdi_i` are low. Otherwise `sdo_en_o`=0.
- R3: The conversion lasts exactly `CONV_CYCLES` clock cycles (default 20). If synchronized `sdi_i` is low at completion, the port then drives `sdo_en_o`=1, `sdo_o`=0.
- R4: If `sdi_i` is still high at completion, no indicator is produced. `sdo_en_o` stays 0 until `cnv_i` goes low.
- R5: `sample_i` is captured in the cycle the conversion completes. Later changes of `sample_i` do not alter the bits read out.
- R6: After the k-th falling `sck_i` edge (k = 1..16), `sdo_o` presents bit 16−k of the captured word, so bit 15 comes first.
- R7: The 17th falling `sck_i` edge releases the output (`sdo_en_o`=0). Further falling edges keep it released.
- R8: A rise of `sdi_i` during the indicator or the readback releases the output at once.
- R9: With `turbo_i` high, a `cnv_i` rise does not start a conversion, and no indicator follows.
- R10: `cnv_i` going low in any non-idle state returns the port to IDLE. Falling `sck_i` edges in IDLE have no effect on `sdo_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_i | input | 1 | Conversion strobe, asynchronous |
| sdi_i | input | 1 | Select / data-in pin, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| turbo_i | input | 1 | Turbo control; the mode runs only when low |
| sample_i | input | 16 | Parallel word standing in for the analog value |
| sdo_o | output | 1 | Serial data output level |
| sdo_en_o | output | 1 | Output enable; 0 means high impedance |

## Verification
Every pin change reaches the outputs three clock edges later: two synchronizer flops, then the state register. The bench therefore drives at a falling clock edge, waits three rising edges and samples at the next falling edge. The indicator is due `CONV_CYCLES` edges after the state enters CONV. The bench samples one cycle before that edge, where the output must still be released, and at that edge, where it must be low. Each serial-clock falling edge is a high phase of three cycles followed by a low phase. The bench samples three cycles into the low phase and compares the bit against the captured word, which is computed in a bench function.

// File: rtl/sar_port_pkg.sv
`timescale 1ns/1ps
package sar_port_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_DONE,
        ST_SHIFT,
        ST_HOLD
    } port_state_e;

    localparam int PIN_SCK = 0;
    localparam int PIN_SDI = 1;
    localparam int PIN_CNV = 2;
    localparam int PIN_CNT = 3;

endpackage

// File: rtl/sar_port_sync.sv
`timescale 1ns/1ps
module sar_port_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    logic [STAGES-1:0][W-1:0] pipe_q;
    logic [W-1:0]             prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
            prev_q <= '0;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], d_i};
            prev_q <= pipe_q[STAGES-1];
        end
    end

    assign q_o = pipe_q[STAGES-1];

    for (genvar b = 0; b < W; b++) begin : g_edge
        assign rise_o[b] =  pipe_q[STAGES-1][b] & ~prev_q[b];
        assign fall_o[b] = ~pipe_q[STAGES-1][b] &  prev_q[b];
    end

endmodule

// File: rtl/sar_port_timer.sv
`timescale 1ns/1ps
module sar_port_timer #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run_i)
            cnt_q <= '0;
        else if (!done_o)
            cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = run_i && (cnt_q == CW'(CYCLES - 1));

    // R3
    timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < CW'(CYCLES)));

endmodule

// File: rtl/sar_port_shifter.sv
`timescale 1ns/1ps
module sar_port_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         adv_i,
    output logic         msb_o,
    output logic         last_o
);

    localparam int BW = $clog2(W);

    logic [W-1:0]  sreg_q;
    logic [BW-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            idx_q  <= '0;
        end else if (load_i) begin
            sreg_q <= data_i;
            idx_q  <= '0;
        end else if (adv_i) begin
            sreg_q <= {sreg_q[W-2:0], 1'b0};
            idx_q  <= idx_q + 1'b1;
        end
    end

    assign msb_o  = sreg_q[W-1];
    assign last_o = (idx_q == BW'(W - 1));

    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i) |-> !last_o);

endmodule

// File: rtl/sar_port_emu.sv
`timescale 1ns/1ps
module sar_port_emu #(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_i,
    input  logic              sdi_i,
    input  logic              sck_i,
    input  logic              turbo_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              sdo_o,
    output logic              sdo_en_o
);

    import sar_port_pkg::*;

    port_state_e state_q, state_d;

    logic [PIN_CNT-1:0] pin_q, pin_rise, pin_fall;
    logic cnv_q, sdi_q, cnv_rise, sdi_rise, sck_fall;
    logic tmr_done, sh_msb, sh_last, sh_load, sh_adv;

    sar_port_sync #(.W(PIN_CNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_i    ({cnv_i, sdi_i, sck_i}),
        .q_o    (pin_q),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    assign cnv_q    = pin_q[PIN_CNV];
    assign sdi_q    = pin_q[PIN_SDI];
    assign cnv_rise = pin_rise[PIN_CNV];
    assign sdi_rise = pin_rise[PIN_SDI];
    assign sck_fall = pin_fall[PIN_SCK];

    sar_port_timer #(.CYCLES(CONV_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q == ST_CONV),
        .done_o (tmr_done)
    );

    assign sh_load = tmr_done;
    assign sh_adv  = (state_q == ST_SHIFT) && (state_d == ST_SHIFT) && sck_fall;

    sar_port_shifter #(.W(DATA_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (sh_load),
        .data_i (sample_i),
        .adv_i  (sh_adv),
        .msb_o  (sh_msb),
        .last_o (sh_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cnv_rise && sdi_q && !turbo_i)
                    state_d = ST_CONV;
            end
            ST_CONV: begin
                if (!cnv_q)
                    state_d = ST_IDLE;
                else if (tmr_done)
                    state_d = sdi_q ? ST_HOLD : ST_DONE;
            end
            ST_DONE: begin
                if (!cnv_q)
                    state_d = ST_IDLE;
                else if (sdi_rise)
                    state_d = ST_HOLD;
                else if (sck_fall)
                    state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (!cnv_q)
                    state_d = ST_IDLE;
                else if (sdi_rise || (sck_fall && sh_last))
                    state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!cnv_q)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        sdo_o    = 1'b0;
        sdo_en_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                sdo_en_o = !cnv_q && !sdi_q;
            end
            ST_CONV, ST_HOLD: begin
                sdo_en_o = 1'b0;
            end
            ST_DONE: begin
                sdo_en_o = 1'b1;
            end
            ST_SHIFT: begin
                sdo_en_o = 1'b1;
                sdo_o    = sh_msb;
            end
            default: sdo_en_o = 1'b0;
        endcase
    end

    // R1
    cs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cnv_rise && sdi_q && !turbo_i) |=> (state_q == ST_CONV && !sdo_en_o));

    // R3
    busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> (sdo_en_o && !sdo_o));

    // R7
    last_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && sck_fall && sh_last && cnv_q) |=> !sdo_en_o);

    // R8
    sdi_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DONE || state_q == ST_SHIFT) && sdi_rise) |=> !sdo_en_o);

    // R9
    turbo_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && turbo_i) |=> (state_q == ST_IDLE));

    // R10
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !cnv_q) |=> (state_q == ST_IDLE));

endmodule

// File: tb/sar_port_emu_bench.sv
`timescale 1ns/1ps
module sar_port_emu_bench;

    localparam int DATA_W      = 16;
    localparam int CONV_CYCLES = 20;
    localparam int WATCHDOG    = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cnv = 1'b0, sdi = 1'b0, sck = 1'b0, turbo = 1'b0;
    logic [DATA_W-1:0] sample = '0;
    logic              sdo, sdo_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sar_port_emu #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_sar_port_emu (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnv_i    (cnv),
        .sdi_i    (sdi),
        .sck_i    (sck),
        .turbo_i  (turbo),
        .sample_i (sample),
        .sdo_o    (sdo),
        .sdo_en_o (sdo_en)
    );

    function automatic logic exp_bit(input logic [DATA_W-1:0] word, input int k);
        return word[DATA_W - k];
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // exp_en=0 means released; level is not compared then
    task automatic check(input string req, input logic exp_en, input logic exp_sdo);
        n_checks++;
        if (sdo_en !== exp_en || (exp_en && sdo !== exp_sdo)) begin
            n_fail++;
            $display("FAIL %s: got en=%b sdo=%b, expected en=%b sdo=%b",
                     req, sdo_en, sdo, exp_en, exp_sdo);
        end
    endtask

    task automatic sck_pulse();
        sck = 1'b1;
        tick(3);
        sck = 1'b0;
        tick(3);
    endtask

    task automatic go_idle();
        cnv = 1'b0;
        sdi = 1'b0;
        sck = 1'b0;
        tick(4);
    endtask

    // start a conversion and reach the indicator (R1, R3, R5)
    task automatic convert(input logic [DATA_W-1:0] word);
        sample = word;
        cnv = 1'b1;
        sdi = 1'b1;
        tick(3);
        check("R1 released at start", 1'b0, 1'b0);
        sdi = 1'b0;
        tick(CONV_CYCLES - 1);
        check("R3 still converting", 1'b0, 1'b0);
        tick(1);
        check("R3 busy indicator low", 1'b1, 1'b0);
        sample = ~word;
    endtask

    initial begin
        logic [DATA_W-1:0] w;
        void'($urandom(32'h1357_2468));
        tick(3);
        check("R2 reset state", 1'b1, 1'b0);
        rst_n = 1'b1;
        tick(2);
        check("R2 idle both low", 1'b1, 1'b0);
        sdi = 1'b1;
        tick(3);
        check("R2 idle sdi high", 1'b0, 1'b0);
        go_idle();

        // directed full readback, R5 R6 R7
        w = 16'hA5C3;
        convert(w);
        for (int k = 1; k <= DATA_W; k++) begin
            sck_pulse();
            check($sformatf("R6 bit %0d", k), 1'b1, exp_bit(w, k));
        end
        sck_pulse();
        check("R7 17th edge releases", 1'b0, 1'b0);
        sck_pulse();
        check("R7 stays released", 1'b0, 1'b0);
        go_idle();
        check("R10 back to idle", 1'b1, 1'b0);

        // R4: sdi held high through conversion
        cnv = 1'b1;
        sdi = 1'b1;
        tick(3 + CONV_CYCLES + 4);
        check("R4 no indicator", 1'b0, 1'b0);
        cnv = 1'b0;
        tick(3);
        sdi = 1'b0;
        tick(3);
        check("R4 idle after cnv low", 1'b1, 1'b0);

        // R9: turbo blocks start
        turbo = 1'b1;
        cnv = 1'b1;
        sdi = 1'b1;
        tick(3);
        sdi = 1'b0;
        tick(CONV_CYCLES + 5);
        check("R9 turbo no indicator", 1'b0, 1'b0);
        turbo = 1'b0;
        go_idle();

        // R10: abort mid-conversion, then sck ignored
        sample = 16'hFFFF;
        cnv = 1'b1;
        sdi = 1'b1;
        tick(3);
        sdi = 1'b0;
        tick(5);
        cnv = 1'b0;
        tick(3);
        check("R10 abort to idle", 1'b1, 1'b0);
        sck_pulse();
        sck_pulse();
        tick(CONV_CYCLES);
        check("R10 sck ignored in idle", 1'b1, 1'b0);

        // random readbacks
        for (int it = 0; it < 40; it++) begin
            int stop_at;
            w = DATA_W'($urandom);
            stop_at = $urandom_range(0, DATA_W + 1);
            go_idle();
            convert(w);
            if (stop_at > DATA_W) begin
                for (int k = 1; k <= DATA_W; k++) begin
                    sck_pulse();
                    check($sformatf("R6 rnd bit %0d", k), 1'b1, exp_bit(w, k));
                end
                sck_pulse();
                check("R7 rnd release", 1'b0, 1'b0);
            end else begin
                for (int k = 1; k <= stop_at; k++) begin
                    sck_pulse();
                    check($sformatf("R6 rnd bit %0d", k), 1'b1, exp_bit(w, k));
                end
                sdi = 1'b1;
                tick(3);
                check("R8 sdi rise releases", 1'b0, 1'b0);
                sck_pulse();
                check("R8 stays released", 1'b0, 1'b0);
            end
            cnv = 1'b0;
            tick(3);
            check("R10 cnv low idle", sdi ? 1'b0 : 1'b1, 1'b0);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule